// File: doc/BRIEF.md
# Status Register and Write Guard for a Serial Memory

This block holds the status register of a byte-wide serial nonvolatile memory. It also judges every write request that the instruction decoder raises. It stores four things: a write-enable flag, a busy flag for a running write cycle, a two-bit protected-region code and a lock-enable bit. The lock-enable bit makes the external write-protect pin take effect. The decoder gives the block single-cycle strobes, and the block answers each write request with a one-cycle grant or a one-cycle deny. It presents the status byte for reads at all times.

A granted request starts a write cycle. The timer outside the block ends that cycle with a done strobe. While the cycle runs, the status byte reads as all ones. A status write stores its new protection fields at the moment it is granted. A write-enable flag is used up by any write request that is judged, whether the write goes ahead or not.

If more than one strobe comes in the same cycle, one is chosen in this fixed order: status write, array write, write-disable, write-enable. The decoder is expected to raise only one strobe at a time.

Top module: `wp_status_ctl`

## Requirements
- R1: After a synchronous reset, `status_o` is 0x00 and `grant_o` and `deny_o` are 0.
- R2: A write-enable strobe while idle sets the enable flag, which reads as status bit 1 in the next cycle.
- R3: A write-disable strobe while idle clears the enable flag.
- R4: A status or array write request made while the enable flag is 0 is denied, and it changes no stored field.
- R5: A granted request pulses `grant_o` in the cycle after the request and starts a write cycle. For that whole cycle `status_o` reads 0xFF, with bit 0 as the busy flag.
- R6: A done strobe during a write cycle ends the cycle and clears both the busy flag and the enable flag.
- R7: A granted status write takes bit 7 of the data as the lock-enable bit and bits 3:2 as the region code, and ignores all other data bits. When idle, status reads {lock-enable, 000, region, enable, 0}. With lock-enable at 0, the pin level has no effect.
- R8: With lock-enable at 1 and `wp_n_i` low, every status write is denied. With the pin high, the write is judged normally.
- R9: An array write is denied when its address lies in the region chosen by the code: 00 none, 01 the top quarter (top two address bits 11), 10 the top half (top address bit 1), 11 everything.
- R10: A denied request made while idle clears the enable flag and leaves the other stored fields unchanged.
- R11: While a write cycle runs, write requests are denied and write-enable and write-disable strobes are ignored. A done strobe while idle has no effect.
- R12: `grant_o` and `deny_o` are never high together, and each is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| stat_wr_i | input | 1 | Status write request |
| stat_data_i | input | 8 | Data for a status write |
| arr_wr_i | input | 1 | Array write request |
| arr_addr_i | input | ADDR_W | Target address of an array write |
| wr_done_i | input | 1 | End of the running write cycle |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Write granted, one-cycle pulse |
| deny_o | output | 1 | Write denied, one-cycle pulse |

## Verification
Every result is due exactly one clock edge after its strobe. The verdict pulse comes from a register loaded at the edge where the request is sampled. The status byte is decoded combinationally from state loaded at that same edge. The bench drives each strobe on a falling edge and removes it on the next falling edge. It samples `grant_o`, `deny_o` and `status_o` at that second falling edge, which is half a period after the edge that updated them. The one-cycle pulse width is checked one cycle later with an idle command.

// File: rtl/wpsr_pkg.sv
package wpsr_pkg;

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned REGION_W = 2;

    // bit positions inside the status byte (read side decodes these)
    localparam int unsigned POS_BUSY   = 0;
    localparam int unsigned POS_ENABLE = 1;
    localparam int unsigned POS_REG_LO = 2;
    localparam int unsigned POS_LOCK   = 7;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_SET_EN,
        CMD_CLR_EN,
        CMD_WR_STATUS,
        CMD_WR_ARRAY
    } cmd_e;

    typedef enum logic [1:0] {
        VERD_NONE,
        VERD_GRANT,
        VERD_DENY
    } verdict_e;

    typedef struct packed {
        logic                lock_en;
        logic [REGION_W-1:0] region;
        logic                enable;
        logic                busy;
    } sr_state_t;

    // is an address (given by its top two bits) inside the protected region
    function automatic logic region_covers(input logic [REGION_W-1:0] code,
                                           input logic [1:0] top2);
        logic hit;
        case (code)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input sr_state_t s);
        logic [STATUS_W-1:0] b;
        if (s.busy) begin
            b = '1;
        end else begin
            b = '0;
            b[POS_LOCK]                     = s.lock_en;
            b[POS_REG_LO +: REGION_W]       = s.region;
            b[POS_ENABLE]                   = s.enable;
            b[POS_BUSY]                     = 1'b0;
        end
        return b;
    endfunction

endpackage

// File: rtl/wpsr_cmd_select.sv
module wpsr_cmd_select
    import wpsr_pkg::*;
(
    input  logic wren_i,
    input  logic wrdi_i,
    input  logic stat_wr_i,
    input  logic arr_wr_i,
    output cmd_e cmd_o
);

    always_comb begin
        if (stat_wr_i)      cmd_o = CMD_WR_STATUS;
        else if (arr_wr_i)  cmd_o = CMD_WR_ARRAY;
        else if (wrdi_i)    cmd_o = CMD_CLR_EN;
        else if (wren_i)    cmd_o = CMD_SET_EN;
        else                cmd_o = CMD_IDLE;
    end

endmodule

// File: rtl/wpsr_guard.sv
module wpsr_guard
    import wpsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  sr_state_t         st_i,
    output verdict_e          verdict_o
);

    localparam int unsigned LOW_W = ADDR_W - 2;

    logic [1:0]       top2;
    logic [LOW_W-1:0] unused_low;
    logic             pin_lock;
    logic             region_hit;

    assign top2       = addr_i[ADDR_W-1 -: 2];
    assign unused_low = addr_i[LOW_W-1:0];
    assign pin_lock   = st_i.lock_en & ~wp_n_i;
    assign region_hit = region_covers(st_i.region, top2);

    always_comb begin
        verdict_o = VERD_NONE;
        case (cmd_i)
            CMD_WR_STATUS: begin
                if (st_i.busy || !st_i.enable || pin_lock) verdict_o = VERD_DENY;
                else                                       verdict_o = VERD_GRANT;
            end
            CMD_WR_ARRAY: begin
                if (st_i.busy || !st_i.enable || region_hit) verdict_o = VERD_DENY;
                else                                         verdict_o = VERD_GRANT;
            end
            default: verdict_o = VERD_NONE;
        endcase
    end

endmodule

// File: rtl/wpsr_state.sv
module wpsr_state
    import wpsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cmd_e                cmd_i,
    input  verdict_e            verdict_i,
    input  logic [STATUS_W-1:0] data_i,
    input  logic                done_i,
    input  logic                wp_n_i,
    output sr_state_t           st_o,
    output logic                grant_o,
    output logic                deny_o
);

    sr_state_t st_q;
    logic      grant_q;
    logic      deny_q;
    logic [STATUS_W-1:0] unused_data;

    assign unused_data = data_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= (verdict_i == VERD_GRANT);
            deny_q  <= (verdict_i == VERD_DENY);
            if (st_q.busy) begin
                if (done_i) begin
                    st_q.busy   <= 1'b0;
                    st_q.enable <= 1'b0;
                end
            end else begin
                case (verdict_i)
                    VERD_GRANT: begin
                        st_q.busy <= 1'b1;
                        if (cmd_i == CMD_WR_STATUS) begin
                            st_q.lock_en <= data_i[POS_LOCK];
                            st_q.region  <= data_i[POS_REG_LO +: REGION_W];
                        end
                    end
                    VERD_DENY: st_q.enable <= 1'b0;
                    default: begin
                        if (cmd_i == CMD_CLR_EN)      st_q.enable <= 1'b0;
                        else if (cmd_i == CMD_SET_EN) st_q.enable <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign st_o    = st_q;
    assign grant_o = grant_q;
    assign deny_o  = deny_q;

    assert_verdict_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(grant_q && deny_q));

    assert_no_enable_deny_R4: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == CMD_WR_STATUS || cmd_i == CMD_WR_ARRAY) && !st_q.enable)
        |=> (deny_q && !grant_q));

    assert_grant_starts_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        grant_q |-> st_q.busy);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (done_i && st_q.busy) |=> (!st_q.busy && !st_q.enable));

    assert_pin_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_WR_STATUS && st_q.lock_en && !wp_n_i) |=> !grant_q);

    assert_full_region_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_WR_ARRAY && st_q.region == 2'b11) |=> !grant_q);

    assert_busy_ignores_en_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !done_i && (cmd_i == CMD_SET_EN || cmd_i == CMD_CLR_EN))
        |=> $stable(st_q.enable));

endmodule

// File: rtl/wp_status_ctl.sv
module wp_status_ctl
    import wpsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_data_i,
    input  logic              arr_wr_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wr_done_i,
    input  logic              wp_n_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o
);

    cmd_e      cmd;
    verdict_e  verdict;
    sr_state_t st;

    wpsr_cmd_select u_sel (
        .wren_i    (wren_i),
        .wrdi_i    (wrdi_i),
        .stat_wr_i (stat_wr_i),
        .arr_wr_i  (arr_wr_i),
        .cmd_o     (cmd)
    );

    wpsr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .cmd_i     (cmd),
        .addr_i    (arr_addr_i),
        .wp_n_i    (wp_n_i),
        .st_i      (st),
        .verdict_o (verdict)
    );

    wpsr_state u_state (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .verdict_i (verdict),
        .data_i    (stat_data_i),
        .done_i    (wr_done_i),
        .wp_n_i    (wp_n_i),
        .st_o      (st),
        .grant_o   (grant_o),
        .deny_o    (deny_o)
    );

    assign status_o = pack_status(st);

    assert_idle_done_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_done_i && !st.busy && cmd == CMD_IDLE) |=> $stable(status_o));

endmodule

// File: tb/tb_wp_status_ctl.sv
module tb_wp_status_ctl;

    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wren_i = 0, wrdi_i = 0, stat_wr_i = 0, arr_wr_i = 0, wr_done_i = 0;
    logic              wp_n_i = 1'b1;
    logic [7:0]        stat_data_i = '0;
    logic [ADDR_W-1:0] arr_addr_i = '0;
    logic [7:0]        status_o;
    logic              grant_o, deny_o;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] obs_s;
    logic       obs_g, obs_d;

    always #10 clk = ~clk;

    wp_status_ctl #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .stat_wr_i(stat_wr_i), .stat_data_i(stat_data_i), .arr_wr_i(arr_wr_i),
        .arr_addr_i(arr_addr_i), .wr_done_i(wr_done_i), .wp_n_i(wp_n_i),
        .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // k: 0 set-enable, 1 clear-enable, 2 status write, 3 array write, 4 done, 5 idle
    task automatic cmd(input int k, input logic [7:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        wren_i    = (k == 0);
        wrdi_i    = (k == 1);
        stat_wr_i = (k == 2);
        arr_wr_i  = (k == 3);
        wr_done_i = (k == 4);
        stat_data_i = d;
        arr_addr_i  = a;
        @(negedge clk);
        {wren_i, wrdi_i, stat_wr_i, arr_wr_i, wr_done_i} = '0;
        obs_s = status_o;
        obs_g = grant_o;
        obs_d = deny_o;
    endtask

    function automatic logic [7:0] idle_status(input logic lk, input logic [1:0] rg, input logic en);
        return {lk, 3'b000, rg, en, 1'b0};
    endfunction

    // write the status register while the pin is released
    task automatic load_status(input logic [7:0] d);
        wp_n_i = 1'b1;
        cmd(0, 8'h00, '0);
        cmd(2, d, '0);
        check("R5 grant on load", {7'd0, obs_g}, 8'h01);
        cmd(4, 8'h00, '0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 status", status_o, 8'h00);
        check("R1 grant", {7'd0, grant_o}, 8'h00);
        check("R1 deny", {7'd0, deny_o}, 8'h00);
    endtask

    task automatic t_enable_flag;
        cmd(0, 8'h00, '0);
        check("R2 set enable", obs_s, 8'h02);
        cmd(1, 8'h00, '0);
        check("R3 clear enable", obs_s, 8'h00);
    endtask

    task automatic t_no_enable;
        cmd(2, 8'hFF, '0);
        check("R4 status deny", {6'd0, obs_g, obs_d}, 8'h01);
        check("R4 status unchanged", obs_s, 8'h00);
        cmd(3, 8'h00, 13'h0010);
        check("R4 array deny", {6'd0, obs_g, obs_d}, 8'h01);
        check("R4 array unchanged", obs_s, 8'h00);
    endtask

    task automatic t_status_write;
        wp_n_i = 1'b0;
        cmd(0, 8'h00, '0);
        cmd(2, 8'h8C, '0);
        check("R7 grant with pin low, lock off", {6'd0, obs_g, obs_d}, 8'h02);
        check("R5 busy reads FF", obs_s, 8'hFF);
        cmd(5, 8'h00, '0);
        check("R12 grant one cycle", {6'd0, obs_g, obs_d}, 8'h00);
        check("R5 still busy", obs_s, 8'hFF);
        cmd(4, 8'h00, '0);
        check("R6 R7 after done", obs_s, idle_status(1'b1, 2'b11, 1'b0));
    endtask

    task automatic t_pin_lock;
        wp_n_i = 1'b0;
        cmd(0, 8'h00, '0);
        cmd(2, 8'h00, '0);
        check("R8 locked deny", {6'd0, obs_g, obs_d}, 8'h01);
        check("R10 deny clears enable only", obs_s, idle_status(1'b1, 2'b11, 1'b0));
        cmd(5, 8'h00, '0);
        check("R12 deny one cycle", {6'd0, obs_g, obs_d}, 8'h00);
        wp_n_i = 1'b1;
        cmd(0, 8'h00, '0);
        cmd(2, 8'h00, '0);
        check("R8 pin high grant", {6'd0, obs_g, obs_d}, 8'h02);
        cmd(4, 8'h00, '0);
        check("R8 cleared fields", obs_s, 8'h00);
        load_status(8'h73);
        check("R7 other data bits ignored", status_o, 8'h00);
        wp_n_i = 1'b0;
        cmd(0, 8'h00, '0);
        cmd(2, 8'h04, '0);
        check("R7 pin no effect when unlocked", {6'd0, obs_g, obs_d}, 8'h02);
        cmd(4, 8'h00, '0);
        check("R7 region 01 stored", obs_s, 8'h04);
        wp_n_i = 1'b1;
    endtask

    task automatic t_regions;
        logic [ADDR_W-1:0] addrs [6];
        addrs[0] = 13'h0000; addrs[1] = 13'h0FFF; addrs[2] = 13'h1000;
        addrs[3] = 13'h17FF; addrs[4] = 13'h1800; addrs[5] = 13'h1FFF;
        for (int rg = 0; rg < 4; rg++) begin
            load_status({4'b0000, rg[1:0], 2'b00});
            for (int i = 0; i < 6; i++) begin
                logic prot;
                case (rg)
                    0: prot = 1'b0;
                    1: prot = (addrs[i] >= 13'h1800);
                    2: prot = (addrs[i] >= 13'h1000);
                    default: prot = 1'b1;
                endcase
                cmd(0, 8'h00, '0);
                cmd(3, 8'h00, addrs[i]);
                check($sformatf("R9 region %0d addr %h", rg, addrs[i]),
                      {6'd0, obs_g, obs_d}, prot ? 8'h01 : 8'h02);
                if (prot) begin
                    check("R10 enable cleared by deny", obs_s, idle_status(1'b0, rg[1:0], 1'b0));
                end else begin
                    cmd(4, 8'h00, '0);
                    check("R6 done after array write", obs_s, idle_status(1'b0, rg[1:0], 1'b0));
                end
            end
        end
        load_status(8'h00);
    endtask

    task automatic t_busy;
        cmd(0, 8'h00, '0);
        cmd(3, 8'h00, 13'h0100);
        check("R5 array grant", {6'd0, obs_g, obs_d}, 8'h02);
        cmd(1, 8'h00, '0);
        check("R11 clear ignored while busy", obs_s, 8'hFF);
        cmd(2, 8'h8C, '0);
        check("R11 status write denied busy", {6'd0, obs_g, obs_d}, 8'h01);
        cmd(3, 8'h00, 13'h0000);
        check("R11 array write denied busy", {6'd0, obs_g, obs_d}, 8'h01);
        cmd(4, 8'h00, '0);
        check("R11 fields untouched after busy", obs_s, 8'h00);
        cmd(0, 8'h00, '0);
        check("R2 enable set", obs_s, 8'h02);
        cmd(4, 8'h00, '0);
        check("R11 idle done no effect", obs_s, 8'h02);
        cmd(1, 8'h00, '0);
        check("R3 clear again", obs_s, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_flag();
        t_no_enable();
        t_status_write();
        t_pin_lock();
        t_regions();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule